// File: doc/BRIEF.md
# Colour Palette Lookup with Sequenced Loading

This block holds a 256-entry colour table and translates pixel indices into 18-bit RGB values for a display pipeline. A processor loads the table through three byte-wide registers: a pixel mask, a write pointer and a data port. Each table entry takes three writes to the data port. Successive triples fill successive entries, so the pointer does not have to be written again between them.

Each colour component is kept at 6-bit precision, taken from the top six bits of the written byte. The three components of an entry are staged and then written into the table together on the blue write. The pointer then advances and wraps from the last entry back to the first.

On the pixel side, the incoming index is ANDed with the mask register before it addresses the table. The looked-up colour is registered, so it appears one clock after the index is presented. The processor can read back the mask register.

Top module: `pal_lut`

## Requirements
- R1: While reset is applied, `pix_rgb` is 0 and the mask reads back as 0xFF. After reset, the write pointer is 0 and the next data write is taken as red.
- R2: A write with `cpu_addr` = 0 loads `cpu_wdata` into the mask. While `cpu_addr` = 0, `cpu_rdata` returns the mask. For any other address, `cpu_rdata` is 0.
- R3: A write with `cpu_addr` = 1 loads the write pointer from `cpu_wdata`. It also returns the component sequence to red, discarding any partly entered triple.
- R4: Writes with `cpu_addr` = 2 are taken in the order red, green, blue. Each component keeps `cpu_wdata[7:2]`. The table entry changes only on the blue write, and then all three components change at once. The stored value is packed as red in bits 17:12, green in bits 11:6 and blue in bits 5:0.
- R5: After each blue write the pointer advances by one, so the next triple loads the next entry.
- R6: The pointer wraps from 255 to 0 after a blue write.
- R7: The table address used for a lookup is `pix_idx` AND mask.
- R8: `pix_rgb` shows the entry selected by the `pix_idx` value sampled on the previous rising clock edge.
- R9: A write with `cpu_addr` = 3 has no effect. Bus values presented while `cpu_wr` is low also have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_wr | input | 1 | Register write strobe, one write per clock with the strobe high |
| cpu_addr | input | 2 | Register select: 0 mask, 1 write pointer, 2 data port, 3 unused |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Mask readback when `cpu_addr` is 0, else 0 |
| pix_idx | input | 8 | Pixel colour index |
| pix_rgb | output | 18 | Registered colour {red, green, blue}, 6 bits each |

## Verification
A wrong pointer or component phase does not show at the ports when it occurs. It shows only as a colour stored at the wrong entry or in the wrong field, visible one clock after that entry is next looked up. The bench therefore reads back neighbouring entries after every load, to catch misplaced writes as well as wrong values. A corrupt mask shows at once on `cpu_rdata` and, one clock later, as a lookup that addresses the wrong entry. An entry committed before its blue write shows as a partly changed colour when the entry is looked up mid-triple.

// File: rtl/pal_pkg.sv
`timescale 1ns/1ps
package pal_pkg;
  localparam logic [1:0] SEL_MASK  = 2'd0;
  localparam logic [1:0] SEL_INDEX = 2'd1;
  localparam logic [1:0] SEL_DATA  = 2'd2;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;
endpackage

// File: rtl/pal_rst_sync.sv
`timescale 1ns/1ps
module pal_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pal_regs.sv
`timescale 1ns/1ps
module pal_regs
  import pal_pkg::*;
#(
  parameter int CPU_W  = 8,
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6,
  localparam int RGB_W = 3 * COMP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       sel,
  input  logic [CPU_W-1:0] wdata,
  output logic [IDX_W-1:0] mask_q,
  output logic [IDX_W-1:0] idx_q,
  output phase_e           phase_q,
  output logic             commit,
  output logic [IDX_W-1:0] commit_addr,
  output logic [RGB_W-1:0] commit_rgb
);
  logic [COMP_W-1:0] comp;
  logic [COMP_W-1:0] red_q, red_d;
  logic [COMP_W-1:0] grn_q, grn_d;
  logic [IDX_W-1:0]  mask_d, idx_d;
  phase_e            phase_d;

  assign comp = wdata[CPU_W-1 -: COMP_W];

  // Next-state decode of the register interface.
  always_comb begin
    mask_d  = mask_q;
    idx_d   = idx_q;
    phase_d = phase_q;
    red_d   = red_q;
    grn_d   = grn_q;
    commit  = 1'b0;
    if (wr_en) begin
      case (sel)
        SEL_MASK:  mask_d = wdata[IDX_W-1:0];
        SEL_INDEX: begin
          idx_d   = wdata[IDX_W-1:0];
          phase_d = PH_RED;
        end
        SEL_DATA: begin
          case (phase_q)
            PH_RED: begin
              red_d   = comp;
              phase_d = PH_GRN;
            end
            PH_GRN: begin
              grn_d   = comp;
              phase_d = PH_BLU;
            end
            default: begin
              commit  = 1'b1;
              idx_d   = idx_q + 1'b1;
              phase_d = PH_RED;
            end
          endcase
        end
        default: ;
      endcase
    end
  end

  assign commit_addr = idx_q;
  assign commit_rgb  = {red_q, grn_q, comp};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      idx_q   <= '0;
      phase_q <= PH_RED;
      red_q   <= '0;
      grn_q   <= '0;
    end else if (wr_en) begin
      mask_q  <= mask_d;
      idx_q   <= idx_d;
      phase_q <= phase_d;
      red_q   <= red_d;
      grn_q   <= grn_d;
    end
  end
endmodule

// File: rtl/pal_store.sv
`timescale 1ns/1ps
module pal_store #(
  parameter int IDX_W = 8,
  parameter int RGB_W = 18,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [RGB_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [RGB_W-1:0] rdata_q
);
  logic [RGB_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= mem[raddr];
  end
endmodule

// File: rtl/pal_lut.sv
`timescale 1ns/1ps
module pal_lut
  import pal_pkg::*;
#(
  parameter int CPU_W  = 8,
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6,
  localparam int RGB_W = 3 * COMP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_wr,
  input  logic [1:0]       cpu_addr,
  input  logic [CPU_W-1:0] cpu_wdata,
  output logic [CPU_W-1:0] cpu_rdata,
  input  logic [IDX_W-1:0] pix_idx,
  output logic [RGB_W-1:0] pix_rgb
);
  logic             rst_sync_n;
  logic [IDX_W-1:0] mask_q;
  logic [IDX_W-1:0] idx_q;
  phase_e           phase_q;
  logic             commit;
  logic [IDX_W-1:0] commit_addr;
  logic [RGB_W-1:0] commit_rgb;
  logic [IDX_W-1:0] look_addr;

  pal_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pal_regs #(.CPU_W(CPU_W), .IDX_W(IDX_W), .COMP_W(COMP_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_en       (cpu_wr),
    .sel         (cpu_addr),
    .wdata       (cpu_wdata),
    .mask_q      (mask_q),
    .idx_q       (idx_q),
    .phase_q     (phase_q),
    .commit      (commit),
    .commit_addr (commit_addr),
    .commit_rgb  (commit_rgb)
  );

  assign look_addr = pix_idx & mask_q;

  pal_store #(.IDX_W(IDX_W), .RGB_W(RGB_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we      (commit),
    .waddr   (commit_addr),
    .wdata   (commit_rgb),
    .raddr   (look_addr),
    .rdata_q (pix_rgb)
  );

  assign cpu_rdata = (cpu_addr == SEL_MASK) ? CPU_W'(mask_q) : '0;
endmodule

// File: rtl/pal_lut_chk.sv
`timescale 1ns/1ps
module pal_lut_chk
  import pal_pkg::*;
#(
  parameter int CPU_W = 8,
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_wr,
  input logic [1:0]       cpu_addr,
  input logic [CPU_W-1:0] cpu_wdata,
  input logic [IDX_W-1:0] mask,
  input logic [IDX_W-1:0] idx,
  input logic [1:0]       phase
);
  // R2
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == SEL_MASK) |=> mask == $past(cpu_wdata[IDX_W-1:0]));

  // R3
  index_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == SEL_INDEX) |=> (idx == $past(cpu_wdata[IDX_W-1:0]) && phase == 2'd0));

  // R4
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == SEL_DATA && phase != 2'd2) |=> (phase == $past(phase) + 2'd1 && $stable(idx)));

  // R5
  index_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == SEL_DATA && phase == 2'd2) |=> (idx == $past(idx) + 1'b1 && phase == 2'd0));

  // R9
  no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_wr || cpu_addr == 2'd3) |=> ($stable(idx) && $stable(phase) && $stable(mask)));

  // R4
  phase_legal_chk: assert property (@(posedge clk) disable iff (!rst_n) phase != 2'd3);
endmodule

bind pal_lut pal_lut_chk #(.CPU_W(CPU_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cpu_wr    (cpu_wr),
  .cpu_addr  (cpu_addr),
  .cpu_wdata (cpu_wdata),
  .mask      (mask_q),
  .idx       (idx_q),
  .phase     (phase_q)
);

// File: tb/pal_lut_bench.sv
`timescale 1ns/1ps
module pal_lut_bench;
  logic        clk;
  logic        rst_n;
  logic        cpu_wr;
  logic [1:0]  cpu_addr;
  logic [7:0]  cpu_wdata;
  logic [7:0]  cpu_rdata;
  logic [7:0]  pix_idx;
  logic [17:0] pix_rgb;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [17:0] ref_mem [256];

  pal_lut u_pal_lut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .pix_idx(pix_idx), .pix_rgb(pix_rgb)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [17:0] pack(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    return {r[7:2], g[7:2], b[7:2]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic load_triple(input logic [7:0] at, input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    cpu_write(2'd2, r); cpu_write(2'd2, g); cpu_write(2'd2, b);
    ref_mem[at] = pack(r, g, b);
  endtask

  task automatic lookup_check(input string req, input logic [7:0] pix, input logic [17:0] exp);
    @(negedge clk);
    pix_idx = pix;
    @(posedge clk);
    @(negedge clk);
    check(req, 32'(pix_rgb), 32'(exp));
  endtask

  task automatic t_reset;
    cpu_wr = 0; cpu_addr = 2'd0; cpu_wdata = 0; pix_idx = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 rgb in reset", 32'(pix_rgb), 0);
    check("R1 mask in reset", 32'(cpu_rdata), 32'hFF);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_first_load;
    // no pointer write: reset pointer is 0, phase red (R1)
    load_triple(8'd0, 8'h11, 8'h22, 8'h33);
    load_triple(8'd1, 8'hFF, 8'h00, 8'h80);
    lookup_check("R1 entry 0 after reset", 8'd0, ref_mem[0]);
    lookup_check("R4 entry 1 packing", 8'd1, pack(8'hFF, 8'h00, 8'h80));
  endtask

  task automatic t_mask_rb;
    cpu_write(2'd0, 8'h3C);
    @(negedge clk); cpu_addr = 2'd0; #1;
    check("R2 mask readback", 32'(cpu_rdata), 32'h3C);
    cpu_addr = 2'd1; #1;
    check("R2 non-mask readback zero", 32'(cpu_rdata), 0);
    cpu_write(2'd0, 8'hFF);
  endtask

  task automatic t_commit_whole;
    cpu_write(2'd1, 8'd5);
    load_triple(8'd5, 8'hFC, 8'h81, 8'h47);
    lookup_check("R4 entry 5", 8'd5, pack(8'hFC, 8'h81, 8'h47));
    cpu_write(2'd1, 8'd5);
    cpu_write(2'd2, 8'h04); cpu_write(2'd2, 8'h08);
    lookup_check("R4 no partial commit", 8'd5, pack(8'hFC, 8'h81, 8'h47));
    cpu_write(2'd2, 8'h0C);
    ref_mem[5] = pack(8'h04, 8'h08, 8'h0C);
    lookup_check("R4 commit on blue", 8'd5, ref_mem[5]);
  endtask

  task automatic t_autoinc;
    cpu_write(2'd1, 8'd10);
    for (int k = 0; k < 3; k++)
      load_triple(8'(10 + k), 8'(8'h40 + 4*k), 8'(8'h90 - 4*k), 8'(8'hC4 + 8*k));
    for (int k = 0; k < 3; k++)
      lookup_check("R5 successive entries", 8'(10 + k), ref_mem[10 + k]);
  endtask

  task automatic t_wrap;
    cpu_write(2'd1, 8'd254);
    load_triple(8'd254, 8'h10, 8'h20, 8'h30);
    load_triple(8'd255, 8'hA0, 8'hB0, 8'hC0);
    load_triple(8'd0,   8'hE4, 8'hD8, 8'hCC);
    lookup_check("R6 entry 254", 8'd254, ref_mem[254]);
    lookup_check("R6 entry 255", 8'd255, ref_mem[255]);
    lookup_check("R6 wrapped to 0", 8'd0, ref_mem[0]);
    lookup_check("R6 entry 1 untouched", 8'd1, ref_mem[1]);
  endtask

  task automatic t_phase_reset;
    cpu_write(2'd1, 8'd20);
    load_triple(8'd20, 8'h5C, 8'h6C, 8'h7C);
    load_triple(8'd21, 8'h00, 8'h00, 8'h00);
    cpu_write(2'd1, 8'd20);
    cpu_write(2'd2, 8'hFC); cpu_write(2'd2, 8'hFC);
    cpu_write(2'd1, 8'd21);
    load_triple(8'd21, 8'h84, 8'h48, 8'h24);
    lookup_check("R3 restarted triple", 8'd21, ref_mem[21]);
    lookup_check("R3 abandoned entry kept", 8'd20, ref_mem[20]);
  endtask

  task automatic t_mask_lookup;
    cpu_write(2'd0, 8'h0F);
    lookup_check("R7 0xFA masked to 0x0A", 8'hFA, ref_mem[10]);
    lookup_check("R7 0x1C masked to 0x0C", 8'h1C, ref_mem[12]);
    cpu_write(2'd0, 8'hFF);
    lookup_check("R7 full mask", 8'hFE, ref_mem[254]);
  endtask

  task automatic t_latency;
    @(negedge clk); pix_idx = 8'd10;
    @(posedge clk); @(negedge clk);
    check("R8 first pixel", 32'(pix_rgb), 32'(ref_mem[10]));
    pix_idx = 8'd11;
    #1;
    check("R8 held until edge", 32'(pix_rgb), 32'(ref_mem[10]));
    @(posedge clk); @(negedge clk);
    check("R8 next pixel", 32'(pix_rgb), 32'(ref_mem[11]));
  endtask

  task automatic t_ignore;
    cpu_write(2'd1, 8'd40);
    cpu_write(2'd3, 8'h55);
    @(negedge clk); cpu_wr = 0; cpu_addr = 2'd1; cpu_wdata = 8'd99;
    @(negedge clk); cpu_addr = 2'd2; cpu_wdata = 8'hFC;
    @(negedge clk); cpu_addr = 2'd0; cpu_wdata = 8'h00;
    @(negedge clk); #1;
    check("R9 mask untouched", 32'(cpu_rdata), 32'hFF);
    load_triple(8'd40, 8'h18, 8'h28, 8'h38);
    lookup_check("R9 pointer and phase untouched", 8'd40, ref_mem[40]);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_first_load();
    t_mask_rb();
    t_commit_whole();
    t_autoinc();
    t_wrap();
    t_phase_reset();
    t_mask_lookup();
    t_latency();
    t_ignore();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule